// File: doc/BRIEF.md
# Boot-Mode Capture and External Interrupt Pins

This block serves a group of dual-purpose input pads. While the chip is held in hardware reset, the pads carry a boot configuration. The block samples that value on each clock and freezes it on the last clock edge before reset is released. The frozen value stays on the `boot_mode` output and sets the chip's initial operating mode, one of sixteen with the default width.

Once reset is released, the same pads become active-low interrupt requests. Each pad passes through a two-stage synchronizer. Each request has its own enable bit and its own choice of level or falling-edge sensing. A request in edge mode is held in a sticky flag until software writes a 1 to clear it.

The block drives two wake outputs. The wait wake is the OR of the pending vector. The stop wake is a combinational path that reacts to an enabled pad going low even when no clock is running.

Top module: `irq_mode_pins`

## Requirements
- R1: While `rst_n` is low, `boot_mode` takes the raw `pin_n` value sampled at each rising clock edge. Bit i of `boot_mode` is pad i.
- R2: After `rst_n` goes high, `boot_mode` keeps the value from the last rising edge at which `rst_n` was low. Later changes on `pin_n` do not affect it.
- R3: While `rst_n` is low, `pending`, `wake_wait` and `wake_stop` are 0. `cfg_enable` and `cfg_edge` are 0, meaning every request is masked and level-sensed. Pad activity during reset raises no interrupt.
- R4: In level mode (`cfg_edge[i]`=0) with `cfg_enable[i]`=1, `pending[i]` is 1 exactly when pad i is low. It follows the pad two rising edges after the pad changes.
- R5: In edge mode (`cfg_edge[i]`=1) with `cfg_enable[i]`=1, a high-to-low change on pad i sets `pending[i]` on the third rising edge after the change. The flag stays set when the pad returns high.
- R6: A cycle with `clr_we`=1 clears, at that edge, every edge-mode flag whose `clr_bits` bit is 1. Bits written 0 have no effect, and a clear has no effect on a level-mode pending bit.
- R7: With `cfg_enable[i]`=0, `pending[i]` is 0. A falling edge that arrives while the request is masked is not recorded, so enabling the request later shows no pending bit.
- R8: `wake_wait` is 1 exactly when any bit of `pending` is 1.
- R9: Out of reset, `wake_stop` rises without any clock edge as soon as an enabled pad goes low. It stays 0 for pads that are masked.
- R10: A cycle with `cfg_we`=1 loads `cfg_enable_d` and `cfg_edge_d`, and the new values appear on `cfg_enable` and `cfg_edge` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low |
| pin_n | input | NPIN | Dual-purpose pads: boot mode during reset, active-low requests afterwards |
| cfg_we | input | 1 | Write strobe for the enable and sense registers |
| cfg_enable_d | input | NPIN | New enable bits, 1 means the request is unmasked |
| cfg_edge_d | input | NPIN | New sense bits, 1 means falling-edge mode |
| clr_we | input | 1 | Write strobe for clearing pending flags |
| clr_bits | input | NPIN | Write-1-to-clear mask for the edge flags |
| boot_mode | output | NPIN | Captured boot mode |
| cfg_enable | output | NPIN | Current enable bits |
| cfg_edge | output | NPIN | Current sense bits |
| pending | output | NPIN | Pending interrupt vector |
| wake_wait | output | 1 | Wake request for the wait state |
| wake_stop | output | 1 | Clock-free wake request for the stop state |

## Verification
The embedded properties check four things on every cycle. The boot mode holds once reset is released. A level-mode pending bit equals the pad value from two edges earlier. A sticky edge flag survives until a clear. A new edge flag appears only after a synchronized high-to-low pattern. Only the bench scenarios can show the rest: the boot value actually captured and the effect of a clear or a mask on the outputs. They also show the stop wake responding between clock edges and requests being silenced by reset.

// File: rtl/irq_mode_pins.sv
module irq_mode_pins #(
  parameter int unsigned NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_n,
  input  logic            cfg_we,
  input  logic [NPIN-1:0] cfg_enable_d,
  input  logic [NPIN-1:0] cfg_edge_d,
  input  logic            clr_we,
  input  logic [NPIN-1:0] clr_bits,
  output logic [NPIN-1:0] boot_mode,
  output logic [NPIN-1:0] cfg_enable,
  output logic [NPIN-1:0] cfg_edge,
  output logic [NPIN-1:0] pending,
  output logic            wake_wait,
  output logic            wake_stop
);

  logic [NPIN-1:0] mode_q;
  logic [NPIN-1:0] s1, s2, s3;
  logic [NPIN-1:0] en_q, edge_q, flag_q;
  logic [NPIN-1:0] fall, set_flag;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= pin_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      s3 <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
    end else if (cfg_we) begin
      en_q   <= cfg_enable_d;
      edge_q <= cfg_edge_d;
    end

  assign fall     = s3 & ~s2;
  assign set_flag = fall & en_q & edge_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= set_flag | (flag_q & ~({NPIN{clr_we}} & clr_bits));

  assign boot_mode  = mode_q;
  assign cfg_enable = en_q;
  assign cfg_edge   = edge_q;
  assign pending    = en_q & ((edge_q & flag_q) | (~edge_q & ~s2));
  assign wake_wait  = |pending;
  assign wake_stop  = rst_n & |(en_q & ~(pin_n & s2));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_mode));

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && en_q[i] && !edge_q[i])
        |-> (pending[i] == !$past(pin_n[i], 2)));

    assert_edge_needs_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4) &&
       $rose(pending[i]) && en_q[i] && edge_q[i] && $past(en_q[i] && edge_q[i]))
        |-> ($past(!pin_n[i], 3) && $past(pin_n[i], 4)));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pending[i]) && $past(en_q[i] && edge_q[i]) && en_q[i] && edge_q[i] &&
       !$past(clr_we && clr_bits[i])) |-> pending[i]);
  end

endmodule

// File: tb/test_irq_mode_pins.sv
module test_irq_mode_pins;
  localparam int N = 4;

  logic clk = 0;
  logic rst_n;
  logic [N-1:0] pin_n, cfg_enable_d, cfg_edge_d, clr_bits;
  logic cfg_we, clr_we;
  logic [N-1:0] boot_mode, cfg_enable, cfg_edge, pending;
  logic wake_wait, wake_stop;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_mode_pins #(.NPIN(N)) i_irq_mode_pins (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n),
    .cfg_we(cfg_we), .cfg_enable_d(cfg_enable_d), .cfg_edge_d(cfg_edge_d),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .boot_mode(boot_mode), .cfg_enable(cfg_enable), .cfg_edge(cfg_edge),
    .pending(pending), .wake_wait(wake_wait), .wake_stop(wake_stop));

  // rows: {enable, edge, pins before, pins after}
  localparam logic [15:0] VEC [8] = '{
    16'b1111_0000_1111_0101,
    16'b1111_1111_1111_0011,
    16'b0101_1111_1111_0000,
    16'b1111_0000_0000_1111,
    16'b1111_1111_0000_0000,
    16'b0000_1111_1111_0000,
    16'b1111_1100_1111_0000,
    16'b1010_0110_1111_1001
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [N-1:0] en, input logic [N-1:0] ed);
    cfg_we = 1; cfg_enable_d = en; cfg_edge_d = ed;
    tick(1);
    cfg_we = 0;
  endtask

  task automatic clear(input logic [N-1:0] b);
    clr_we = 1; clr_bits = b;
    tick(1);
    clr_we = 0; clr_bits = '0;
  endtask

  function automatic logic [N-1:0] exp_pend(input logic [N-1:0] en, input logic [N-1:0] ed,
                                            input logic [N-1:0] b, input logic [N-1:0] a);
    return en & ((ed & b & ~a) | (~ed & ~a));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_n = 4'b1010; cfg_we = 0; clr_we = 0;
    cfg_enable_d = '0; cfg_edge_d = '0; clr_bits = '0;
    tick(3);
    check("R1 boot mode in reset", boot_mode, 4'b1010);
    check("R3 pending in reset", pending, 0);
    check("R3 enable reset value", cfg_enable, 0);
    check("R3 edge reset value", cfg_edge, 0);
    check("R3 wake_wait in reset", wake_wait, 0);
    check("R3 wake_stop in reset", wake_stop, 0);
    pin_n = 4'b0110; tick(1);
    check("R1 boot mode tracks pads", boot_mode, 4'b0110);
    pin_n = 4'b1001; tick(2);
    rst_n = 1; tick(1);
    pin_n = 4'b0110; tick(3);
    check("R2 boot mode frozen", boot_mode, 4'b1001);
    pin_n = '1; tick(4);
    check("R2 boot mode after pad change", boot_mode, 4'b1001);

    write_cfg(4'b1100, 4'b0101);
    check("R10 enable written", cfg_enable, 4'b1100);
    check("R10 edge written", cfg_edge, 4'b0101);

    foreach (VEC[k]) begin
      logic [N-1:0] en, ed, b, a, e;
      {en, ed, b, a} = VEC[k];
      e = exp_pend(en, ed, b, a);
      pin_n = b;
      write_cfg(en, ed);
      tick(4);
      clear('1);
      pin_n = a;
      tick(5);
      check($sformatf("R4 R5 R7 row %0d pending", k), pending, e);
      check($sformatf("R8 row %0d wake_wait", k), wake_wait, |e);
      check($sformatf("R9 row %0d wake_stop", k), wake_stop, |(en & ~a));
    end

    // R4 latency
    pin_n = '1; write_cfg('1, '0); tick(4);
    pin_n[0] = 0; tick(1);
    check("R4 not yet after one edge", pending, 0);
    tick(1);
    check("R4 set after two edges", pending, 4'b0001);
    pin_n[0] = 1; tick(2);
    check("R4 follows release", pending, 0);

    // R5 latency and stickiness
    write_cfg('1, '1); tick(4); clear('1);
    pin_n[1] = 0; tick(2);
    check("R5 not yet after two edges", pending, 0);
    tick(1);
    check("R5 set after three edges", pending, 4'b0010);
    pin_n[1] = 1; tick(4);
    check("R5 sticky after pad high", pending, 4'b0010);

    // R6 clear
    clear(4'b0001);
    check("R6 zero bits no effect", pending, 4'b0010);
    clear(4'b0010);
    check("R6 write-one clears", pending, 0);
    write_cfg('1, '0);
    pin_n[2] = 0; tick(3);
    clear('1);
    check("R6 clear ignored in level mode", pending, 4'b0100);
    pin_n = '1; tick(4);

    // R7 masked edge not recorded
    write_cfg('0, '1); tick(2);
    pin_n[3] = 0; tick(4);
    check("R7 masked pending", pending, 0);
    write_cfg('1, '1); tick(2);
    check("R7 edge while masked lost", pending, 0);
    pin_n = '1; tick(4);

    // R9 clock-free stop wake
    write_cfg(4'b0001, '0); tick(4);
    pin_n[1] = 0; #0.5;
    check("R9 masked pad no stop wake", wake_stop, 0);
    pin_n[0] = 0; #0.5;
    check("R9 stop wake without clock", wake_stop, 1);

    // R3 reset silences requests
    pin_n = '0; #0.5;
    rst_n = 0; #0.5;
    check("R3 wake_stop in reset", wake_stop, 0);
    check("R3 pending in reset", pending, 0);
    check("R3 enable cleared", cfg_enable, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule